// File: doc/BRIEF.md
# Quadrature Position and Index Counter

This block turns the two phase lines and the index line of an incremental encoder into a position count, a revolution count and a direction flag. The three encoder lines are first resynchronised to the core clock. The decoded motion then drives a position register that wraps within a programmable range. Each index pulse moves a revolution counter up or down, according to the current direction of travel.

Two input conventions are supported. In quadrature mode the two phase lines are decoded, with either double or fourfold edge resolution. In clock/direction mode one line is a step strobe and the other gives the direction as a level. The direction sense and the index polarity can each be inverted. One-cycle command inputs clear the position and revolution counters. A mode bit makes every detected index pulse clear the position. Three position comparators and one revolution comparator report equality, and each position comparator also reports a combined match with the revolution comparator. Single-cycle event pulses mark counted steps, phase errors, direction reversals and index detections.

Top module: `qpos_counter`

## Requirements
- R1: After reset, `pos_o`, `idx_cnt_o` and `dir_o` are 0 and all event outputs are low; `dir_o` = 0 means forward and 1 means backward.
- R2: In quadrature mode (`cfg_clkdir_i` = 0), a phase A edge where the new A differs from B is a forward step, and a phase B edge where the new B equals A is a forward step; the opposite cases are backward steps. With `cfg_x4_i` = 1 edges on both phases count. With `cfg_x4_i` = 0 only phase A edges count, and a phase B edge neither counts nor changes `dir_o`.
- R3: In clock/direction mode (`cfg_clkdir_i` = 1), each rising edge of phase A is one step: forward when phase B is low, backward when it is high. Falling A edges and B changes alone do not count, and `cfg_x4_i` has no effect.
- R4: `cfg_dir_inv_i` = 1 complements the decoded direction before it is used for counting and shown on `dir_o`. `dir_o` holds the direction of the last counted step. `ev_dir_chg_o` pulses when a step's direction differs from the held one.
- R5: A forward step from a position greater than or equal to `max_pos_i` gives 0. A backward step from 0 gives `max_pos_i`. Any other step moves the position by one.
- R6: In quadrature mode, a change of both phases in the same sample pulses `ev_phase_err_o` and leaves the position and direction unchanged. `ev_enc_clk_o` pulses once for every counted step and never together with `ev_phase_err_o`.
- R7: An index pulse is a rising edge of the index line, or a falling edge when `cfg_idx_inv_i` = 1. It pulses `ev_idx_o`. It adds one to `idx_cnt_o` when the direction in effect after that sample is forward and subtracts one when that direction is backward, modulo 2^IDX_W. Changing `cfg_idx_inv_i` alone produces no index pulse.
- R8: A one-cycle `cmd_clr_pos_i` sets the position to 0 in the next cycle, taking priority over a step. `cmd_clr_idx_i` does the same for the index count. With `cfg_idx_clr_pos_i` = 1, every index pulse sets the position to 0 instead of stepping it.
- R9: `pos_eq_o[n]` is high while `pos_o` equals compare channel n, held in `pos_cmp_i[n*POS_W +: POS_W]`. `rev_eq_o` is high while `idx_cnt_o` equals `idx_cmp_i`. `combo_eq_o[n]` is high exactly when both `pos_eq_o[n]` and `rev_eq_o` are high.
- R10: A change on an encoder line is reflected in the counters and event pulses after the third rising clock edge that follows it, and not earlier. Each event pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enc_a_i | input | 1 | Encoder phase A, or step strobe in clock/direction mode |
| enc_b_i | input | 1 | Encoder phase B, or direction level in clock/direction mode |
| enc_idx_i | input | 1 | Encoder index line |
| cfg_clkdir_i | input | 1 | 0 selects quadrature mode, 1 selects clock/direction mode |
| cfg_x4_i | input | 1 | 1 counts edges on both phases in quadrature mode |
| cfg_dir_inv_i | input | 1 | Complements the decoded direction |
| cfg_idx_inv_i | input | 1 | Makes the falling index edge the detected one |
| cfg_idx_clr_pos_i | input | 1 | Makes each index pulse clear the position |
| cmd_clr_pos_i | input | 1 | One-cycle command that clears the position |
| cmd_clr_idx_i | input | 1 | One-cycle command that clears the index count |
| max_pos_i | input | POS_W | Highest position value before the count wraps |
| pos_cmp_i | input | N_CMP*POS_W | Position compare values, channel n in bits n*POS_W upward |
| idx_cmp_i | input | IDX_W | Index count compare value |
| pos_o | output | POS_W | Current position |
| idx_cnt_o | output | IDX_W | Current index (revolution) count |
| dir_o | output | 1 | Held direction, 1 = backward |
| ev_idx_o | output | 1 | Pulse: index detected |
| ev_dir_chg_o | output | 1 | Pulse: direction reversed |
| ev_phase_err_o | output | 1 | Pulse: both phases changed in one sample |
| ev_enc_clk_o | output | 1 | Pulse: a step was counted |
| pos_eq_o | output | N_CMP | Position equals compare channel n |
| rev_eq_o | output | 1 | Index count equals its compare value |
| combo_eq_o | output | N_CMP | Position channel n and index compare both match |

## Verification
The hardest situations to reach from the ports are the ones where several things happen in the same sample: an index edge arriving together with a step that reverses direction, a double-phase change while the position sits at a wrap boundary, and compare matches that coincide with a particular revolution count. The stimulus is a pseudo-random walk that toggles A, B, both phases, or a phase together with the index, driven by a shift-register sequence. The walk runs under every combination of mode, edge resolution, direction inversion and index polarity. The wrap limit is small and the compare values lie inside the range, so wraps at both ends and combined matches happen often. Directed Gray-code runs, command pulses, index-driven position clears and a cycle-exact latency probe complete the set.

// File: rtl/qpos_pkg.sv
package qpos_pkg;

  typedef enum logic {
    SIG_QUAD   = 1'b0,
    SIG_CLKDIR = 1'b1
  } sig_mode_e;

  typedef struct packed {
    logic      idx_clr_pos;
    logic      idx_inv;
    logic      dir_inv;
    logic      x4;
    sig_mode_e mode;
  } qpos_cfg_t;

endpackage

// File: rtl/qpos_sync.sv
module qpos_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_head
        assign stage_d[s] = d_i;
      end else begin : g_tail
        assign stage_d[s] = stage_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/qpos_decode.sv
module qpos_decode
  import qpos_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  sig_mode_e mode_i,
  input  logic      x4_i,
  input  logic      dir_inv_i,
  input  logic      idx_inv_i,
  input  logic      a_i,
  input  logic      b_i,
  input  logic      idx_i,
  output logic      step_o,
  output logic      rev_o,
  output logic      idx_pulse_o,
  output logic      dir_o,
  output logic      ev_clk_o,
  output logic      ev_err_o,
  output logic      ev_dir_o,
  output logic      ev_idx_o
);

  logic prev_a_q, prev_b_q, prev_idx_q;
  logic dir_q, ev_clk_q, ev_err_q, ev_dir_q, ev_idx_q;
  logic a_chg, b_chg, step, err, fwd, rev_step, idx_pulse;
  logic dir_en, ev_dir_d;

  // edge classification of the synchronised phases
  always_comb begin
    a_chg = a_i ^ prev_a_q;
    b_chg = b_i ^ prev_b_q;
    step  = 1'b0;
    err   = 1'b0;
    fwd   = 1'b1;
    if (mode_i == SIG_CLKDIR) begin
      step = a_chg & a_i;
      fwd  = ~b_i;
    end else if (a_chg && b_chg) begin
      err = 1'b1;
    end else if (a_chg) begin
      step = 1'b1;
      fwd  = a_i ^ b_i;
    end else if (b_chg && x4_i) begin
      step = 1'b1;
      fwd  = ~(a_i ^ b_i);
    end
  end

  // polarity handling relative to the raw previous index level
  always_comb begin
    rev_step  = ~fwd ^ dir_inv_i;
    idx_pulse = idx_inv_i ? (prev_idx_q & ~idx_i) : (~prev_idx_q & idx_i);
    dir_en    = step;
    ev_dir_d  = step & (rev_step != dir_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_a_q   <= 1'b0;
      prev_b_q   <= 1'b0;
      prev_idx_q <= 1'b0;
      ev_clk_q   <= 1'b0;
      ev_err_q   <= 1'b0;
      ev_dir_q   <= 1'b0;
      ev_idx_q   <= 1'b0;
    end else begin
      prev_a_q   <= a_i;
      prev_b_q   <= b_i;
      prev_idx_q <= idx_i;
      ev_clk_q   <= step;
      ev_err_q   <= err;
      ev_dir_q   <= ev_dir_d;
      ev_idx_q   <= idx_pulse;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= 1'b0;
    else if (dir_en) dir_q <= rev_step;
  end

  assign step_o      = step;
  assign rev_o       = step ? rev_step : dir_q;
  assign idx_pulse_o = idx_pulse;
  assign dir_o       = dir_q;
  assign ev_clk_o    = ev_clk_q;
  assign ev_err_o    = ev_err_q;
  assign ev_dir_o    = ev_dir_q;
  assign ev_idx_o    = ev_idx_q;

  // R4: a reported reversal always coincides with a flip of the held direction
  assert_dir_flip_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    ev_dir_q |-> (dir_q != $past(dir_q)));

endmodule

// File: rtl/qpos_pos_ctr.sv
module qpos_pos_ctr #(
  parameter int POS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             rev_i,
  input  logic             clr_i,
  input  logic [POS_W-1:0] max_i,
  output logic [POS_W-1:0] pos_o
);

  localparam logic [POS_W-1:0] ONE = POS_W'(1);

  logic [POS_W-1:0] pos_q, pos_d;
  logic             pos_en;

  always_comb begin
    pos_en = clr_i | step_i;
    pos_d  = pos_q;
    if (clr_i) begin
      pos_d = '0;
    end else if (step_i) begin
      if (rev_i) pos_d = (pos_q == '0)   ? max_i : pos_q - ONE;
      else       pos_d = (pos_q >= max_i) ? '0    : pos_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos_q <= '0;
    else if (pos_en) pos_q <= pos_d;
  end

  assign pos_o = pos_q;

  assert_fwd_wrap_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !rev_i && !clr_i && (pos_q >= max_i)) |=> (pos_q == '0));

  assert_back_wrap_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && rev_i && !clr_i && (pos_q == '0)) |=> (pos_q == $past(max_i)));

  assert_pos_clear_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (pos_q == '0));

endmodule

// File: rtl/qpos_idx_ctr.sv
module qpos_idx_ctr #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_i,
  input  logic             rev_i,
  input  logic             clr_i,
  output logic [IDX_W-1:0] idx_o
);

  localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;

  always_comb begin
    idx_en = clr_i | pulse_i;
    if (clr_i)      idx_d = '0;
    else if (rev_i) idx_d = idx_q - ONE;
    else            idx_d = idx_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign idx_o = idx_q;

  assert_idx_moves_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_i && !clr_i) |=> (idx_q != $past(idx_q)));

  assert_idx_clear_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (idx_q == '0));

endmodule

// File: rtl/qpos_match.sv
module qpos_match #(
  parameter int POS_W = 16,
  parameter int IDX_W = 8,
  parameter int N_CMP = 3
) (
  input  logic [POS_W-1:0]       pos_i,
  input  logic [N_CMP*POS_W-1:0] cmp_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  logic [IDX_W-1:0]       idx_cmp_i,
  output logic [N_CMP-1:0]       pos_eq_o,
  output logic                   rev_eq_o,
  output logic [N_CMP-1:0]       combo_o
);

  assign rev_eq_o = (idx_i == idx_cmp_i);

  generate
    for (genvar n = 0; n < N_CMP; n++) begin : g_chan
      assign pos_eq_o[n] = (pos_i == cmp_i[n*POS_W +: POS_W]);
      assign combo_o[n]  = pos_eq_o[n] & rev_eq_o;
    end
  endgenerate

endmodule

// File: rtl/qpos_counter.sv
module qpos_counter
  import qpos_pkg::*;
#(
  parameter int POS_W       = 16,
  parameter int IDX_W       = 8,
  parameter int N_CMP       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enc_a_i,
  input  logic                   enc_b_i,
  input  logic                   enc_idx_i,
  input  logic                   cfg_clkdir_i,
  input  logic                   cfg_x4_i,
  input  logic                   cfg_dir_inv_i,
  input  logic                   cfg_idx_inv_i,
  input  logic                   cfg_idx_clr_pos_i,
  input  logic                   cmd_clr_pos_i,
  input  logic                   cmd_clr_idx_i,
  input  logic [POS_W-1:0]       max_pos_i,
  input  logic [N_CMP*POS_W-1:0] pos_cmp_i,
  input  logic [IDX_W-1:0]       idx_cmp_i,
  output logic [POS_W-1:0]       pos_o,
  output logic [IDX_W-1:0]       idx_cnt_o,
  output logic                   dir_o,
  output logic                   ev_idx_o,
  output logic                   ev_dir_chg_o,
  output logic                   ev_phase_err_o,
  output logic                   ev_enc_clk_o,
  output logic [N_CMP-1:0]       pos_eq_o,
  output logic                   rev_eq_o,
  output logic [N_CMP-1:0]       combo_eq_o
);

  localparam int N_LINES = 3;

  logic [1:0]         rst_pipe_q;
  logic               rst_core_n;
  logic [N_LINES-1:0] sync_q;
  qpos_cfg_t          cfg;
  logic               step, rev, idx_pulse, pos_clr;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  always_comb begin
    cfg.mode        = sig_mode_e'(cfg_clkdir_i);
    cfg.x4          = cfg_x4_i;
    cfg.dir_inv     = cfg_dir_inv_i;
    cfg.idx_inv     = cfg_idx_inv_i;
    cfg.idx_clr_pos = cfg_idx_clr_pos_i;
  end

  qpos_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d_i   ({enc_idx_i, enc_b_i, enc_a_i}),
    .q_o   (sync_q)
  );

  qpos_decode i_decode (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .mode_i      (cfg.mode),
    .x4_i        (cfg.x4),
    .dir_inv_i   (cfg.dir_inv),
    .idx_inv_i   (cfg.idx_inv),
    .a_i         (sync_q[0]),
    .b_i         (sync_q[1]),
    .idx_i       (sync_q[2]),
    .step_o      (step),
    .rev_o       (rev),
    .idx_pulse_o (idx_pulse),
    .dir_o       (dir_o),
    .ev_clk_o    (ev_enc_clk_o),
    .ev_err_o    (ev_phase_err_o),
    .ev_dir_o    (ev_dir_chg_o),
    .ev_idx_o    (ev_idx_o)
  );

  assign pos_clr = cmd_clr_pos_i | (cfg.idx_clr_pos & idx_pulse);

  qpos_pos_ctr #(.POS_W(POS_W)) i_pos (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .step_i (step),
    .rev_i  (rev),
    .clr_i  (pos_clr),
    .max_i  (max_pos_i),
    .pos_o  (pos_o)
  );

  qpos_idx_ctr #(.IDX_W(IDX_W)) i_idx (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .pulse_i (idx_pulse),
    .rev_i   (rev),
    .clr_i   (cmd_clr_idx_i),
    .idx_o   (idx_cnt_o)
  );

  qpos_match #(.POS_W(POS_W), .IDX_W(IDX_W), .N_CMP(N_CMP)) i_match (
    .pos_i     (pos_o),
    .cmp_i     (pos_cmp_i),
    .idx_i     (idx_cnt_o),
    .idx_cmp_i (idx_cmp_i),
    .pos_eq_o  (pos_eq_o),
    .rev_eq_o  (rev_eq_o),
    .combo_o   (combo_eq_o)
  );

  // R6: a phase error leaves the position where it was unless a clear hit it
  assert_err_holds_pos_R6 : assert property (@(posedge clk) disable iff (!rst_core_n)
    (ev_phase_err_o && !$past(cmd_clr_pos_i) && !(ev_idx_o && $past(cfg_idx_clr_pos_i)))
      |-> (pos_o == $past(pos_o)));

  assert_err_not_clk_R6 : assert property (@(posedge clk) disable iff (!rst_core_n)
    !(ev_phase_err_o && ev_enc_clk_o));

endmodule

// File: tb/test_qpos_counter.sv
module test_qpos_counter;

  localparam int PW = 16;
  localparam int IW = 8;
  localparam int NC = 3;
  localparam logic [PW-1:0] MAXP = 16'd5;
  localparam logic [IW-1:0] IDXC = 8'd1;

  logic clk = 1'b0;
  logic rst_n;
  logic enc_a, enc_b, enc_idx;
  logic cfg_clkdir, cfg_x4, cfg_dir_inv, cfg_idx_inv, cfg_idx_clr_pos;
  logic cmd_clr_pos, cmd_clr_idx;
  logic [PW-1:0]    max_pos;
  logic [NC*PW-1:0] pos_cmp;
  logic [IW-1:0]    idx_cmp;
  logic [PW-1:0]    pos_o;
  logic [IW-1:0]    idx_cnt_o;
  logic             dir_o, ev_idx_o, ev_dir_chg_o, ev_phase_err_o, ev_enc_clk_o, rev_eq_o;
  logic [NC-1:0]    pos_eq_o, combo_eq_o;

  always #2 clk = ~clk;

  qpos_counter #(.POS_W(PW), .IDX_W(IW), .N_CMP(NC)) i_qpos_counter (
    .clk(clk), .rst_n(rst_n),
    .enc_a_i(enc_a), .enc_b_i(enc_b), .enc_idx_i(enc_idx),
    .cfg_clkdir_i(cfg_clkdir), .cfg_x4_i(cfg_x4), .cfg_dir_inv_i(cfg_dir_inv),
    .cfg_idx_inv_i(cfg_idx_inv), .cfg_idx_clr_pos_i(cfg_idx_clr_pos),
    .cmd_clr_pos_i(cmd_clr_pos), .cmd_clr_idx_i(cmd_clr_idx),
    .max_pos_i(max_pos), .pos_cmp_i(pos_cmp), .idx_cmp_i(idx_cmp),
    .pos_o(pos_o), .idx_cnt_o(idx_cnt_o), .dir_o(dir_o),
    .ev_idx_o(ev_idx_o), .ev_dir_chg_o(ev_dir_chg_o), .ev_phase_err_o(ev_phase_err_o),
    .ev_enc_clk_o(ev_enc_clk_o), .pos_eq_o(pos_eq_o), .rev_eq_o(rev_eq_o),
    .combo_eq_o(combo_eq_o)
  );

  int n_chk = 0;
  int n_fail = 0;

  logic [PW-1:0] m_pos;
  logic [IW-1:0] m_idx;
  logic          m_dir;
  logic          pa, pb, pi;
  logic          e_clk, e_err, e_dir, e_idx;
  logic [15:0]   lfsr;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // expected behaviour of one sample, from the requirements
  task automatic model_step(input logic na, input logic nb, input logic ni);
    logic ac, bc, stp, er, fwd, rv, ip;
    ac = na ^ pa; bc = nb ^ pb;
    stp = 1'b0; er = 1'b0; fwd = 1'b1;
    if (cfg_clkdir) begin
      stp = ac & na; fwd = ~nb;
    end else if (ac && bc) er = 1'b1;
    else if (ac) begin stp = 1'b1; fwd = na ^ nb; end
    else if (bc && cfg_x4) begin stp = 1'b1; fwd = ~(na ^ nb); end
    ip = cfg_idx_inv ? (pi & ~ni) : (~pi & ni);
    e_clk = stp; e_err = er; e_dir = 1'b0; e_idx = ip;
    if (stp) begin
      rv = ~fwd ^ cfg_dir_inv;
      e_dir = (rv != m_dir);
      m_dir = rv;
    end
    if (cfg_idx_clr_pos && ip) m_pos = '0;
    else if (stp) begin
      if (m_dir) m_pos = (m_pos == '0) ? max_pos : m_pos - 16'd1;
      else       m_pos = (m_pos >= max_pos) ? '0 : m_pos + 16'd1;
    end
    if (ip) m_idx = m_dir ? m_idx - 8'd1 : m_idx + 8'd1;
    pa = na; pb = nb; pi = ni;
  endtask

  task automatic check_match();
    for (int n = 0; n < NC; n++) begin
      chk("R9", $sformatf("pos match %0d", n), int'(pos_eq_o[n]),
          int'(m_pos == pos_cmp[n*PW +: PW]));
      chk("R9", $sformatf("combined match %0d", n), int'(combo_eq_o[n]),
          int'((m_pos == pos_cmp[n*PW +: PW]) && (m_idx == idx_cmp)));
    end
    chk("R9", "revolution match", int'(rev_eq_o), int'(m_idx == idx_cmp));
  endtask

  task automatic apply(input logic na, input logic nb, input logic ni, input string tag);
    enc_a = na; enc_b = nb; enc_idx = ni;
    model_step(na, nb, ni);
    repeat (3) @(negedge clk);
    chk(tag,  "position",     int'(pos_o), int'(m_pos));
    chk("R7", "index count",  int'(idx_cnt_o), int'(m_idx));
    chk("R4", "direction",    int'(dir_o), int'(m_dir));
    chk("R6", "clock event",  int'(ev_enc_clk_o), int'(e_clk));
    chk("R6", "phase error",  int'(ev_phase_err_o), int'(e_err));
    chk("R4", "dir change",   int'(ev_dir_chg_o), int'(e_dir));
    chk("R7", "index event",  int'(ev_idx_o), int'(e_idx));
    check_match();
  endtask

  task automatic fwd_step(input string tag);
    if (pa == pb) apply(~pa, pb, pi, tag);
    else          apply(pa, ~pb, pi, tag);
  endtask

  task automatic back_step(input string tag);
    if (pa == pb) apply(pa, ~pb, pi, tag);
    else          apply(~pa, pb, pi, tag);
  endtask

  // configuration change: no event may appear while it settles (R7)
  task automatic set_cfg(input logic [3:0] c);
    {cfg_idx_inv, cfg_dir_inv, cfg_x4, cfg_clkdir} = c;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R7", "no index event on cfg change", int'(ev_idx_o), 0);
      chk("R6", "no clock event on cfg change", int'(ev_enc_clk_o), 0);
    end
  endtask

  task automatic clr_pos();
    cmd_clr_pos = 1'b1;
    @(negedge clk);
    cmd_clr_pos = 1'b0;
    m_pos = '0;
    chk("R8", "position after clear command", int'(pos_o), 0);
  endtask

  task automatic clr_idx();
    cmd_clr_idx = 1'b1;
    @(negedge clk);
    cmd_clr_idx = 1'b0;
    m_idx = '0;
    chk("R8", "index after clear command", int'(idx_cnt_o), 0);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    enc_a = 0; enc_b = 0; enc_idx = 0;
    cfg_clkdir = 0; cfg_x4 = 1; cfg_dir_inv = 0; cfg_idx_inv = 0; cfg_idx_clr_pos = 0;
    cmd_clr_pos = 0; cmd_clr_idx = 0;
    max_pos = MAXP;
    pos_cmp = {16'd5, 16'd3, 16'd1};
    idx_cmp = IDXC;
    m_pos = '0; m_idx = '0; m_dir = 1'b0; pa = 0; pb = 0; pi = 0;
    lfsr = 16'hACE1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1", "reset position", int'(pos_o), 0);
    chk("R1", "reset index", int'(idx_cnt_o), 0);
    chk("R1", "reset direction", int'(dir_o), 0);
    chk("R1", "reset events", int'({ev_idx_o, ev_dir_chg_o, ev_phase_err_o, ev_enc_clk_o}), 0);

    // R5 wrap at both ends with 4X quadrature
    for (int k = 0; k < 8; k++) fwd_step("R5");
    chk("R5", "forward wrap result", int'(pos_o), 2);
    for (int k = 0; k < 5; k++) back_step("R5");
    chk("R5", "backward wrap result", int'(pos_o), 3);

    // R10 latency: unchanged after two edges, updated after the third
    begin
      logic [PW-1:0] old;
      old = pos_o;
      if (pa == pb) enc_a = ~pa; else enc_b = ~pb;
      model_step(enc_a, enc_b, enc_idx);
      repeat (2) @(negedge clk);
      chk("R10", "position before third edge", int'(pos_o), int'(old));
      @(negedge clk);
      chk("R10", "position after third edge", int'(pos_o), int'(m_pos));
      chk("R10", "clock pulse after third edge", int'(ev_enc_clk_o), 1);
      @(negedge clk);
      chk("R10", "clock pulse lasts one cycle", int'(ev_enc_clk_o), 0);
    end

    // R2 / R3 / R4 / R6 / R7 sweep over every mode combination
    for (int c = 0; c < 16; c++) begin
      set_cfg(4'(c));
      for (int s = 0; s < 40; s++) begin
        string tg;
        tg = cfg_clkdir ? "R3" : "R2";
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (lfsr[2:0])
          3'd0, 3'd1, 3'd2: apply(~pa, pb, pi, tg);
          3'd3, 3'd4:       apply(pa, ~pb, pi, tg);
          3'd5:             apply(~pa, ~pb, pi, "R6");
          3'd6:             apply(pa, pb, ~pi, "R7");
          default:          apply(~pa, pb, ~pi, tg);
        endcase
      end
    end

    // R8 clear commands, also taking priority over a coincident step
    set_cfg(4'b0010);
    fwd_step("R8"); fwd_step("R8");
    clr_pos();
    fwd_step("R8");
    apply(pa, pb, ~pi, "R8");
    clr_idx();
    chk("R8", "position kept by index clear", int'(pos_o), int'(m_pos));

    // R8 index pulse clears position when enabled
    cfg_idx_clr_pos = 1'b1;
    fwd_step("R8"); fwd_step("R8");
    if (pi) apply(pa, pb, 1'b0, "R8");
    apply(pa, pb, 1'b1, "R8");
    chk("R8", "position after index clear", int'(pos_o), 0);
    cfg_idx_clr_pos = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule